// File: doc/BRIEF.md
# Main Oscillator Failure Guard

This block watches the main oscillator clock from the always-running low-speed clock domain and decides when that oscillator has died. A toggle flop clocked by the main clock is synchronised into the low-speed domain. A small counter measures how many low-speed cycles pass without the toggle moving. When the counter reaches its limit while monitoring is enabled, a sticky failure flag is set.

While the flag is set, any system clock request that names the main or PLL source is steered to the low-speed source. The programmed 3-bit select code is never altered. Only the effective code on the output changes. The same flag also moves the clock-accuracy monitor's main-derived clock onto the low-speed source.

On the rising edge of the flag the block raises a one-cycle interrupt request. A separately enabled request asks the timer outputs to go to high impedance. Software clears the flag with a strobe, but the strobe is obeyed only while the select code points away from the main and PLL sources.

Top module: `osc_fail_guard`

## Requirements
- R1: While `rst_ni` is low and on the first cycles after release, `fail_flag_o`, `irq_o`, `hiz_req_o` and `mon_low_o` are 0, and `eff_src_o` equals `src_sel_i`.
- R2: With `det_en_i` = 1, once the main clock stops toggling, `fail_flag_o` becomes 1. It is still 0 five low-speed cycles after the last main edge and is 1 by nine cycles after it. The detection window is 4 low-speed cycles with no synchronised toggle change.
- R3: A running main clock, including one whose half-period is 1.3 low-speed periods, never sets `fail_flag_o`.
- R4: Monitoring is off after reset. While `det_en_i` = 0, a stopped main clock never sets the flag.
- R5: Driving `det_en_i` to 0 does not clear a flag that is already set.
- R6: Select codes are 3'b000 (low-speed), 3'b010 (main) and 3'b100 (PLL); every other value counts as a non-main source. While the flag is 1 and `src_sel_i` is 010 or 100, `eff_src_o` is 000. In every other case `eff_src_o` equals `src_sel_i`.
- R7: A `flag_clr_i` pulse is ignored while `src_sel_i` is 010 or 100.
- R8: A `flag_clr_i` pulse with any other select code clears the flag on the next low-speed edge.
- R9: If a detection and a valid clear strobe occur in the same cycle, the flag stays 1.
- R10: `irq_o` is high for exactly one low-speed cycle, in the cycle the flag rises.
- R11: `hiz_req_o` equals `fail_flag_o` AND `hiz_en_i`.
- R12: `mon_low_o` is 1 exactly while the flag is 1, which moves the accuracy monitor's main-derived clock onto the low-speed source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Main oscillator clock being watched |
| lclk_i | input | 1 | Always-on low-speed clock; the block's own clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| det_en_i | input | 1 | Enables stop monitoring |
| src_sel_i | input | 3 | Programmed system clock source code |
| flag_clr_i | input | 1 | Software strobe that clears the failure flag |
| hiz_en_i | input | 1 | Allows the high-impedance request |
| fail_flag_o | output | 1 | Sticky main oscillator failure flag |
| eff_src_o | output | 3 | Source code after failover steering |
| mon_low_o | output | 1 | Accuracy monitor clock taken from the low-speed source |
| irq_o | output | 1 | One-cycle interrupt on flag rise |
| hiz_req_o | output | 1 | Request to float timer outputs |

## Verification
The embedded properties check the following on every cycle:
- the stall counter stays within its limit;
- the flag only rises while monitoring is enabled;
- a flag held with a main or PLL selection cannot fall;
- a steered code is always the low-speed code;
- the interrupt and high-impedance requests never appear without the flag.

The detection latency window, the absence of false trips on a slow but running main clock, the sweeps over all eight select codes for steering and for clear acceptance, and the clash between clear and detection can only be shown by the bench's timed scenarios.

// File: rtl/osc_guard_pkg.sv
package osc_guard_pkg;
  localparam int SRC_W = 3;
  localparam logic [SRC_W-1:0] SRC_LOW  = 3'b000;
  localparam logic [SRC_W-1:0] SRC_MAIN = 3'b010;
  localparam logic [SRC_W-1:0] SRC_PLL  = 3'b100;

  function automatic logic is_main_path(logic [SRC_W-1:0] s);
    return (s == SRC_MAIN) || (s == SRC_PLL);
  endfunction
endpackage

// File: rtl/ofg_toggle.sv
module ofg_toggle (
  input  logic mclk_i,
  input  logic rst_ni,
  output logic tgl_o
);
  always_ff @(posedge mclk_i or negedge rst_ni) begin
    if (!rst_ni) tgl_o <= 1'b0;
    else         tgl_o <= ~tgl_o;
  end
endmodule

// File: rtl/ofg_sync.sv
module ofg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic chg_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];
  end

  assign chg_o = sync_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/ofg_stall_cnt.sv
module ofg_stall_cnt #(
  parameter int LIMIT = 4,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic chg_i,
  output logic stop_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!en_i || chg_i)          cnt_q <= '0;
    else if (cnt_q != CNT_W'(LIMIT))  cnt_q <= cnt_q + 1'b1;
  end

  assign stop_o = en_i && (cnt_q == CNT_W'(LIMIT));

  // R2: counter saturates at the window limit
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(LIMIT));
  // R4: counter held clear while monitoring is off
  a_r4_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/ofg_src_route.sv
module ofg_src_route
  import osc_guard_pkg::*;
(
  input  logic             fail_i,
  input  logic [SRC_W-1:0] sel_i,
  output logic [SRC_W-1:0] eff_o,
  output logic             mon_low_o
);
  always_comb begin
    eff_o = sel_i;
    if (fail_i && is_main_path(sel_i)) eff_o = SRC_LOW;
  end

  assign mon_low_o = fail_i;

  // R6: steered code is always low-speed
  a_r6_route_low: assert final (!(fail_i && is_main_path(sel_i)) || eff_o == SRC_LOW);
endmodule

// File: rtl/osc_fail_guard.sv
module osc_fail_guard
  import osc_guard_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STALL_LIMIT = 4
) (
  input  logic             mclk_i,
  input  logic             lclk_i,
  input  logic             rst_ni,
  input  logic             det_en_i,
  input  logic [SRC_W-1:0] src_sel_i,
  input  logic             flag_clr_i,
  input  logic             hiz_en_i,
  output logic             fail_flag_o,
  output logic [SRC_W-1:0] eff_src_o,
  output logic             mon_low_o,
  output logic             irq_o,
  output logic             hiz_req_o
);
  logic tgl, chg, stop, clr_ok;
  logic flag_q, irq_q;

  ofg_toggle u_toggle (
    .mclk_i (mclk_i),
    .rst_ni (rst_ni),
    .tgl_o  (tgl)
  );

  ofg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (lclk_i),
    .rst_ni  (rst_ni),
    .async_i (tgl),
    .chg_o   (chg)
  );

  ofg_stall_cnt #(.LIMIT(STALL_LIMIT)) u_cnt (
    .clk_i  (lclk_i),
    .rst_ni (rst_ni),
    .en_i   (det_en_i),
    .chg_i  (chg),
    .stop_o (stop)
  );

  // detection has priority over a clear in the same cycle
  assign clr_ok = flag_clr_i && !is_main_path(src_sel_i) && !stop;

  always_ff @(posedge lclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= stop && !flag_q;
      if (stop)        flag_q <= 1'b1;
      else if (clr_ok) flag_q <= 1'b0;
    end
  end

  ofg_src_route u_route (
    .fail_i    (flag_q),
    .sel_i     (src_sel_i),
    .eff_o     (eff_src_o),
    .mon_low_o (mon_low_o)
  );

  assign fail_flag_o = flag_q;
  assign irq_o       = irq_q;
  assign hiz_req_o   = flag_q && hiz_en_i;

  // R4: flag only rises while monitoring is enabled
  a_r4_rise_needs_en: assert property (@(posedge lclk_i) disable iff (!rst_ni)
    $rose(fail_flag_o) |-> $past(det_en_i));
  // R7: clear blocked under main or PLL selection
  a_r7_clear_blocked: assert property (@(posedge lclk_i) disable iff (!rst_ni)
    (fail_flag_o && is_main_path(src_sel_i)) |=> fail_flag_o);
  // R10: interrupt marks the rising edge only
  a_r10_irq_edge: assert property (@(posedge lclk_i) disable iff (!rst_ni)
    irq_o |-> (fail_flag_o && !$past(fail_flag_o)));
  // R11: float request only with the flag
  a_r11_hiz_flag: assert property (@(posedge lclk_i) disable iff (!rst_ni)
    hiz_req_o |-> fail_flag_o);
endmodule

// File: tb/osc_fail_guard_bench.sv
`timescale 1ns/1ps
module osc_fail_guard_bench;
  logic       mclk_i = 1'b0;
  logic       lclk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       det_en_i = 1'b0;
  logic [2:0] src_sel_i = 3'b010;
  logic       flag_clr_i = 1'b0;
  logic       hiz_en_i = 1'b1;
  logic       fail_flag_o, mon_low_o, irq_o, hiz_req_o;
  logic [2:0] eff_src_o;

  int  errors = 0;
  int  checks = 0;
  int  irq_seen = 0;
  bit  mrun = 1'b1;
  real mhalf = 3.5;
  bit  done = 1'b0;

  osc_fail_guard u_osc_fail_guard (
    .mclk_i(mclk_i), .lclk_i(lclk_i), .rst_ni(rst_ni), .det_en_i(det_en_i),
    .src_sel_i(src_sel_i), .flag_clr_i(flag_clr_i), .hiz_en_i(hiz_en_i),
    .fail_flag_o(fail_flag_o), .eff_src_o(eff_src_o), .mon_low_o(mon_low_o),
    .irq_o(irq_o), .hiz_req_o(hiz_req_o)
  );

  always #5 lclk_i = ~lclk_i;
  always begin
    #(mhalf);
    if (mrun) mclk_i = ~mclk_i;
  end
  always @(negedge lclk_i) if (irq_o === 1'b1) irq_seen++;

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge lclk_i);
  endtask

  function automatic bit main_code(input logic [2:0] s);
    return (s == 3'b010) || (s == 3'b100);
  endfunction

  task automatic pulse_clr();
    flag_clr_i = 1'b1;
    cyc(1);
    flag_clr_i = 1'b0;
    cyc(1);
  endtask

  task automatic arm_flag();
    det_en_i = 1'b1;
    cyc(8);
    det_en_i = 1'b0;
    cyc(2);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    // R1
    chk(fail_flag_o == 0 && irq_o == 0, "R1 flag/irq in reset", {fail_flag_o, irq_o}, 0);
    chk(hiz_req_o == 0 && mon_low_o == 0, "R1 hiz/mon in reset", {hiz_req_o, mon_low_o}, 0);
    chk(eff_src_o == src_sel_i, "R1 eff in reset", eff_src_o, src_sel_i);
    rst_ni = 1'b1;
    cyc(2);
    chk(fail_flag_o == 0 && eff_src_o == 3'b010, "R1 after release", fail_flag_o, 0);

    // R4: stopped main with monitoring off
    mrun = 1'b0;
    cyc(12);
    chk(fail_flag_o == 0, "R4 disabled no detect", fail_flag_o, 0);

    // R3: running main, fast then slow
    mrun = 1'b1;
    det_en_i = 1'b1;
    cyc(20);
    chk(fail_flag_o == 0, "R3 fast main", fail_flag_o, 0);
    mhalf = 13.0;
    cyc(60);
    chk(fail_flag_o == 0 && irq_seen == 0, "R3 slow main", fail_flag_o, 0);
    mhalf = 3.5;
    cyc(10);

    // R2 / R10: stop detection latency and single interrupt
    mrun = 1'b0;
    cyc(5);
    chk(fail_flag_o == 0, "R2 not before window", fail_flag_o, 0);
    cyc(4);
    chk(fail_flag_o == 1, "R2 detected", fail_flag_o, 1);
    cyc(6);
    chk(irq_seen == 1, "R10 single irq pulse", irq_seen, 1);
    chk(mon_low_o == 1, "R12 monitor on low-speed", mon_low_o, 1);

    // R11
    hiz_en_i = 1'b1; cyc(1);
    chk(hiz_req_o == 1, "R11 hiz enabled", hiz_req_o, 1);
    hiz_en_i = 1'b0; cyc(1);
    chk(hiz_req_o == 0, "R11 hiz gated", hiz_req_o, 0);
    hiz_en_i = 1'b1;

    // R6 with flag set, all codes
    for (int c = 0; c < 8; c++) begin
      src_sel_i = 3'(c);
      cyc(1);
      chk(eff_src_o == (main_code(3'(c)) ? 3'b000 : 3'(c)), "R6 steer flag=1",
          eff_src_o, main_code(3'(c)) ? 0 : c);
    end

    // R9: detection beats clear (main still stopped, enabled)
    src_sel_i = 3'b000;
    pulse_clr();
    chk(fail_flag_o == 1, "R9 detect wins over clear", fail_flag_o, 1);

    // R5
    det_en_i = 1'b0;
    cyc(3);
    chk(fail_flag_o == 1, "R5 disable keeps flag", fail_flag_o, 1);

    // R7 / R8 sweep
    for (int c = 0; c < 8; c++) begin
      if (fail_flag_o !== 1'b1) arm_flag();
      src_sel_i = 3'(c);
      irq_seen = 0;
      pulse_clr();
      if (main_code(3'(c)))
        chk(fail_flag_o == 1, "R7 clear ignored", fail_flag_o, 1);
      else
        chk(fail_flag_o == 0, "R8 clear accepted", fail_flag_o, 0);
    end

    // R6 / R12 with flag clear
    for (int c = 0; c < 8; c++) begin
      src_sel_i = 3'(c);
      cyc(1);
      chk(eff_src_o == 3'(c), "R6 pass flag=0", eff_src_o, c);
    end
    chk(mon_low_o == 0 && hiz_req_o == 0, "R12 monitor back on main", mon_low_o, 0);

    // R3 after recovery
    mrun = 1'b1;
    det_en_i = 1'b1;
    irq_seen = 0;
    cyc(30);
    chk(fail_flag_o == 0 && irq_seen == 0, "R3 recovered main", fail_flag_o, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule